// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a clocked host and an 8192-by-8 asynchronous static RAM. The host issues one read or one write at a time through a valid/ready request carrying a 13-bit address, a write flag and a write byte. The block turns each request into a pin-level cycle on the RAM. It drives a low-true select, a high-true select, a low-true output enable, a low-true write strobe, the address and the shared 8-bit data bus.

Every phase of a RAM cycle is stretched to a whole number of clock periods, and each of these counts is a parameter with a minimum of one:
- read access
- write strobe width
- write data setup
- bus turnaround
- total cycle time

Between requests the RAM is parked deselected, with the low-true select high so that it sits in standby. Read data is registered at the end of the access window and handed back with a one-cycle strobe.

The controller never drives the data bus while the RAM's output enable is low. It drives the bus only after the output enable has been high for the turnaround count. It keeps the write byte on the bus for one cycle after the write strobe rises, which meets a zero hold time against the strobe that ends the write.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after a synchronous reset (rst_n low at a clock edge), `req_ready` is 1, `rsp_valid` is 0, `ram_sel_n` is 1, `ram_sel_p` is 0, `ram_oe_n` is 1 and `ram_we_n` is 1.
- R2: Whenever `req_ready` is 1, the RAM is parked deselected (`ram_sel_n` = 1, `ram_sel_p` = 0), with `ram_oe_n` and `ram_we_n` both 1.
- R3: A read accepted at a clock edge holds both selects active, `ram_oe_n` = 0 and `ram_we_n` = 1 for exactly ACC_CYC cycles, starting with the cycle after acceptance. The bus is sampled at the edge that ends that window.
- R4: `rsp_valid` is 1 for exactly one cycle, the (ACC_CYC+1)-th cycle after acceptance, and `rsp_rdata` then carries the byte sampled at the end of the access window.
- R5: A write holds `ram_we_n` low for exactly max(WP_CYC, DS_CYC) cycles, with both selects active and `ram_oe_n` = 1 for the whole write. The selects stay active for TURN_CYC + max(WP_CYC, DS_CYC) + 1 cycles.
- R6: The controller drives the bus only when `ram_oe_n` has been 1 for at least TURN_CYC cycles. Its write strobe falls in cycle TURN_CYC+1 after acceptance. The write byte stays on the bus in the cycle after `ram_we_n` returns high, while the selects are still active.
- R7: `ram_addr` takes the request address at acceptance and does not change while either select is active.
- R8: After a read is accepted, `req_ready` stays 0 for max(CYC_MIN, ACC_CYC+1) cycles. After a write it stays 0 for max(CYC_MIN, TURN_CYC + max(WP_CYC, DS_CYC) + 2) cycles.
- R9: A read returns the byte most recently written to the same address, across the whole address range, and also when the read directly follows the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request taken at an edge where valid and ready are both 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 13 | RAM address pins |
| ram_sel_n | output | 1 | RAM select, active low (high = standby) |
| ram_sel_p | output | 1 | RAM select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq | inout | 8 | Shared RAM data bus |

## Verification
Cycles are counted from the accepting edge, and the bench samples every pin at the falling edge of each following cycle. With the bench configuration (access 2, strobe 2, setup 3, turnaround 1, cycle 4), the rules are:
- Read enable is due in cycles 1 and 2.
- The read strobe is due in cycle 3.
- Ready is due back in cycle 5 after a read and in cycle 7 after a write.
- The write strobe is due in cycles 2 to 4, with hold data checked in cycle 5.

The RAM model returns the inverted byte until the output enable window has lasted the access count. A read sampled one edge early therefore shows up as a data mismatch. The model also measures the strobe width and the data setup at the edge that ends each write.

// File: rtl/sram_async_pkg.sv
// Package: shared state and pin-control types for the asynchronous SRAM
// cycle sequencer. Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package sram_async_pkg;

    // Cycle phases of one RAM access.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_RECOVER  = 3'd5
    } seq_state_e;

    // Pin-level intent, active-high, converted to pin polarity at the top.
    typedef struct packed {
        logic sel;       // both selects active
        logic rd_oe;     // output enable active
        logic wr_strobe; // write strobe active
        logic bus_drv;   // controller drives the data bus
    } pin_ctl_t;

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_async_timer.sv
// Module: phase length down-counter. Loaded with a phase length (>= 1)
// on the edge that enters a phase; flags the last cycle of that phase.
// Assumes the loader never requests a length of zero.
module sram_async_timer #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // Count the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase ends in the cycle where one count remains.
    assign last = (cnt_q == W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0))
        else $error("phase length of zero loaded"); // R3

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)))
        else $error("phase length not taken"); // R5

endmodule

// File: rtl/sram_async_fsm.sv
// Module: cycle sequencer. Walks each accepted request through its
// phases, tracks the total cycle span so that the minimum cycle time is
// met, and registers the pin controls from the next state so that every
// RAM pin comes straight from a flop. Assumes all counts are >= 1.
module sram_async_fsm
    import sram_async_pkg::*;
#(
    parameter int unsigned ACC_CYC  = 2,
    parameter int unsigned WP_CYC   = 2,
    parameter int unsigned DS_CYC   = 3,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned CYC_MIN  = 4,
    parameter int unsigned TW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    input  logic          tmr_last,
    output pin_ctl_t      ctl_q
);

    localparam int unsigned PULSE_CYC = max2(WP_CYC, DS_CYC);
    localparam int unsigned SW        = $clog2(CYC_MIN + 1);
    localparam logic [SW-1:0] SPAN_LAST = SW'(CYC_MIN - 1);

    seq_state_e    state_q, state_d;
    logic [SW-1:0] span_q;
    logic          span_done;

    // Map a phase to the pins it asserts.
    function automatic pin_ctl_t ctl_of(input seq_state_e s);
        pin_ctl_t c;
        c = '0;
        case (s)
            ST_RD_ACC:   begin c.sel = 1'b1; c.rd_oe = 1'b1; end
            ST_WR_TURN:  begin c.sel = 1'b1; end
            ST_WR_PULSE: begin c.sel = 1'b1; c.wr_strobe = 1'b1; c.bus_drv = 1'b1; end
            ST_WR_HOLD:  begin c.sel = 1'b1; c.bus_drv = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACC) && tmr_last;
    assign span_done = (span_q >= SPAN_LAST);

    // Choose the next phase and the length to load for it.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_TURN;
                        tmr_val = TW'(TURN_CYC);
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = TW'(ACC_CYC);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_last) state_d = ST_RECOVER;
            end
            ST_WR_TURN: begin
                if (tmr_last) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (span_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Count busy cycles since acceptance, saturating at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) span_q <= '0;
        else if (!span_done)              span_q <= span_q + 1'b1;
    end

    // Register the pin controls from the phase about to start.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_of(state_d);
    end

    AST_PARKED_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ctl_q == '0))
        else $error("RAM not parked while ready"); // R2

    AST_STROBE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.wr_strobe && ctl_q.rd_oe))
        else $error("write strobe with output enable"); // R5

    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wr_strobe |-> ctl_q.sel)
        else $error("write strobe while deselected"); // R5

    AST_STROBE_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.wr_strobe) |-> (ctl_q.bus_drv && ctl_q.sel))
        else $error("data or select dropped with strobe"); // R6

    AST_READY_AFTER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(span_done))
        else $error("ready before cycle time"); // R8

endmodule

// File: rtl/sram_async_datapath.sv
// Module: address/data holding and bus handling. Latches the request at
// acceptance, drives the write byte onto the shared bus when told to,
// samples the bus at the end of a read and raises a one-cycle strobe.
// Assumes bus_drv comes from a flop and is never set with output enable.
module sram_async_datapath #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              bus_drv,
    input  logic              sel,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Take address and write byte when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the end of the access window and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= ram_dq;
        end
    end

    assign ram_addr = addr_q;
    assign ram_dq   = bus_drv ? wdata_q : {DATA_W{1'bz}};

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("read strobe longer than one cycle"); // R4

    AST_ADDR_STABLE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(addr_q))
        else $error("address moved while selected"); // R7

    AST_NO_ACCEPT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !sel)
        else $error("request taken while selected"); // R7

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: top of the asynchronous SRAM cycle sequencer. Connects the
// sequencer, the phase timer and the datapath, and converts the
// active-high pin intents to pin polarity. Assumes every count
// parameter is at least one.
module sram_async_ctrl
    import sram_async_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ACC_CYC  = 2,
    parameter int unsigned WP_CYC   = 2,
    parameter int unsigned DS_CYC   = 3,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned CYC_MIN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel_p,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    inout  wire  [DATA_W-1:0] ram_dq
);

    localparam int unsigned PULSE_CYC = max2(WP_CYC, DS_CYC);
    localparam int unsigned TMR_MAX   = max2(max2(ACC_CYC, TURN_CYC), PULSE_CYC);
    localparam int unsigned TW        = $clog2(TMR_MAX + 1);
    localparam int unsigned QW        = $clog2(TURN_CYC + 1);

    logic          accept, capture, tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;
    pin_ctl_t      ctl;

    sram_async_fsm #(
        .ACC_CYC (ACC_CYC),
        .WP_CYC  (WP_CYC),
        .DS_CYC  (DS_CYC),
        .TURN_CYC(TURN_CYC),
        .CYC_MIN (CYC_MIN),
        .TW      (TW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_last (tmr_last),
        .ctl_q    (ctl)
    );

    sram_async_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    sram_async_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (capture),
        .bus_drv  (ctl.bus_drv),
        .sel      (ctl.sel),
        .ram_addr (ram_addr),
        .ram_dq   (ram_dq),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign ram_sel_n = ~ctl.sel;
    assign ram_sel_p = ctl.sel;
    assign ram_oe_n  = ~ctl.rd_oe;
    assign ram_we_n  = ~ctl.wr_strobe;

    // Count cycles the output enable pin has been high, for the turnaround check.
    logic [QW-1:0] oe_quiet_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !ram_oe_n)             oe_quiet_q <= '0;
        else if (oe_quiet_q < QW'(TURN_CYC)) oe_quiet_q <= oe_quiet_q + 1'b1;
    end

    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.bus_drv |-> (ram_oe_n && (oe_quiet_q >= QW'(TURN_CYC))))
        else $error("bus driven before turnaround"); // R6

    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_we_n && !ram_oe_n))
        else $error("write strobe and output enable together"); // R5

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel_n != ram_sel_p)
        else $error("selects disagree"); // R3

endmodule

// File: tb/sram_async_ctrl_bench.sv
// Bench: full-range write/read sweeps against a behavioural RAM model.
module sram_async_ctrl_bench;

    localparam int ACC   = 2;
    localparam int WP    = 2;
    localparam int DS    = 3;
    localparam int TURN  = 1;
    localparam int CYC   = 4;
    localparam int PULSE = (WP > DS) ? WP : DS;
    localparam int N_RD  = (CYC > ACC + 1) ? CYC : ACC + 1;
    localparam int N_WR  = (CYC > TURN + PULSE + 2) ? CYC : TURN + PULSE + 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [12:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] ram_addr;
    logic        ram_sel_n, ram_sel_p, ram_oe_n, ram_we_n;
    wire  [7:0]  dq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sram_async_ctrl #(
        .ACC_CYC(ACC), .WP_CYC(WP), .DS_CYC(DS), .TURN_CYC(TURN), .CYC_MIN(CYC)
    ) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel_p(ram_sel_p),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq(dq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29) ^ (a >> 5) ^ 8'h3C);
    endfunction

    // ---------------- behavioural RAM model ----------------
    logic [7:0] mem [logic [12:0]];
    wire  m_sel = !ram_sel_n && ram_sel_p;
    wire  m_rd  = m_sel && !ram_oe_n && ram_we_n;
    wire  m_wr  = m_sel && !ram_we_n;
    int   acc_run = 0;
    logic [7:0] m_word, m_out;
    logic       pend = 1'b0;
    logic [12:0] pend_a;
    logic [7:0]  pend_d;
    int   wp_run, ds_run;

    always @* begin
        m_word = mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
        m_out  = (acc_run >= ACC - 1) ? m_word : ~m_word;
    end
    assign dq = m_rd ? m_out : 8'bz;

    always @(posedge clk) begin
        acc_run <= m_rd ? acc_run + 1 : 0;
        if (m_wr) begin
            if (!pend) begin
                wp_run <= 1;
                ds_run <= 1;
            end else begin
                wp_run <= wp_run + 1;
                ds_run <= (dq == pend_d) ? ds_run + 1 : 1;
            end
            pend   <= 1'b1;
            pend_a <= ram_addr;
            pend_d <= dq;
        end else if (pend) begin
            chk(wp_run >= WP, "R5 strobe width", wp_run, WP);
            chk(ds_run >= DS, "R5 data setup", ds_run, DS);
            chk(dq == pend_d, "R6 data hold at strobe end", int'(dq), int'(pend_d));
            mem[pend_a] = pend_d;
            pend <= 1'b0;
        end
    end

    // ---------------- request tasks ----------------
    task automatic do_write(input int a, input logic [7:0] d);
        int we_cnt = 0, we_first = 0, sel_cnt = 0, oe_cnt = 0, ready_k = 0;
        bit addr_bad = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'(a); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 64; k++) begin
            if (k > 1) @(negedge clk);
            if (req_ready) begin
                ready_k = k;
                chk(ram_sel_n && !ram_sel_p && ram_oe_n && ram_we_n, "R2 parked", int'(ram_sel_n), 1);
                break;
            end
            if (!ram_we_n) begin
                we_cnt++;
                if (we_first == 0) we_first = k;
            end
            if (!ram_oe_n) oe_cnt++;
            if (!ram_sel_n) begin
                sel_cnt++;
                if (ram_addr != 13'(a)) addr_bad = 1'b1;
            end
            if (k == TURN + PULSE + 1)
                chk(dq == d && !ram_sel_n && ram_we_n, "R6 hold cycle data", int'(dq), int'(d));
        end
        chk(we_cnt == PULSE, "R5 strobe cycles", we_cnt, PULSE);
        chk(we_first == TURN + 1, "R6 strobe start", we_first, TURN + 1);
        chk(oe_cnt == 0, "R5 oe during write", oe_cnt, 0);
        chk(sel_cnt == TURN + PULSE + 1, "R5 select cycles", sel_cnt, TURN + PULSE + 1);
        chk(!addr_bad, "R7 write address", int'(ram_addr), a);
        chk(ready_k == N_WR + 1, "R8 write busy", ready_k - 1, N_WR);
    endtask

    task automatic do_read(input int a, input logic [7:0] exp);
        int oe_cnt = 0, oe_first = 0, we_cnt = 0, rsp_cnt = 0, rsp_k = 0, ready_k = 0;
        logic [7:0] got = 8'h00;
        bit addr_bad = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 13'(a);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 64; k++) begin
            if (k > 1) @(negedge clk);
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_k = k;
                got = rsp_rdata;
            end
            if (req_ready) begin
                ready_k = k;
                break;
            end
            if (!ram_oe_n) begin
                oe_cnt++;
                if (oe_first == 0) oe_first = k;
                if (ram_sel_n || !ram_sel_p) addr_bad = 1'b1;
            end
            if (!ram_we_n) we_cnt++;
            if (!ram_sel_n && ram_addr != 13'(a)) addr_bad = 1'b1;
        end
        chk(oe_cnt == ACC, "R3 enable cycles", oe_cnt, ACC);
        chk(oe_first == 1, "R3 enable start", oe_first, 1);
        chk(we_cnt == 0, "R3 strobe during read", we_cnt, 0);
        chk(!addr_bad, "R7 read address/select", int'(ram_addr), a);
        chk(rsp_cnt == 1, "R4 strobe count", rsp_cnt, 1);
        chk(rsp_k == ACC + 1, "R4 strobe cycle", rsp_k, ACC + 1);
        chk(got == exp, "R9 read data", int'(got), int'(exp));
        chk(ready_k == N_RD + 1, "R8 read busy", ready_k - 1, N_RD);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(ram_sel_n == 1'b1 && ram_sel_p == 1'b0, "R1 selects", int'(ram_sel_p), 0);
        chk(ram_oe_n == 1'b1 && ram_we_n == 1'b1, "R1 enables", int'(ram_oe_n & ram_we_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && ram_sel_n, "R2 idle after reset", int'(ram_sel_n), 1);

        for (int a = 0; a < 8192; a++) do_write(a, pat(a));
        for (int a = 0; a < 8192; a++) do_read(a, pat(a));
        for (int a = 0; a < 128; a++) begin
            do_write(a * 61, ~pat(a * 61));
            do_read(a * 61, ~pat(a * 61));
        end
        do_read(8191, pat(8191));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule